// File: doc/BRIEF.md
# Coalescing Redo Log Buffer

This block sits between a transactional data cache and persistent memory and keeps at most one redo record per cache line that the running transaction has written. A store names a line address, a byte mask and a full line of data; the masked bytes are folded into the record for that line, so many stores to one line cost a single write to the log. Records hold new values only and leave the buffer in two cases. A miss on a full buffer pushes the oldest record out. When the transaction ends, every remaining record is flushed.

Records go out on a valid/ready port, each tagged with a running log tail index. After an end-of-transaction request the block flushes its records in the order they were allocated. It then raises a persisted flag, which the commit logic waits for. An abort throws away every held record without writing it. The flag stays up until the next transaction's first store is taken.

Top module: `redo_coalesce_buf`

## Requirements
- R1: After reset, log_valid and persisted are 0, log_tail is 0 and st_ready is 1.
- R2: A store whose line is already held emits no record. It overwrites only the bytes whose st_mask bit is 1, and the other bytes of that record keep their earlier values.
- R3: A store whose line is not held and that finds a free slot emits no record. In the eventual record, bytes never written read as zero, and log_mask (bit i covers byte i, data bits 8i+7..8i) is the OR of all accepted store masks for that line.
- R4: A store that misses while all N_SLOTS slots are full evicts the record allocated earliest. That record is on the log port in the cycle after the store is accepted.
- R5: While log_valid is 1 and log_ready is 0, log_valid, log_line, log_mask, log_data and log_tail hold their values.
- R6: st_ready is 0 while flushing, while a record waits with log_ready low, and in any cycle where tx_end or tx_abort is 1.
- R7: A one-cycle tx_end pulse flushes every held record in allocation order. With an empty buffer it writes nothing.
- R8: log_tail starts at 0 and rises by exactly 1 for each record accepted (log_valid and log_ready both 1). Each record carries the tail value current while it is offered. An abort does not change log_tail.
- R9: persisted rises only after the last record of a flush has been accepted and is never 1 while log_valid is 1. Once up, it holds until a store is accepted, and it is 0 in the following cycle.
- R10: tx_abort empties the buffer and no discarded record ever appears on the log port. A later flush then writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_line | input | LINE_AW | Cache line address of the store |
| st_mask | input | LINE_BYTES | Byte enables, bit i covers byte i |
| st_data | input | 8*LINE_BYTES | Line data, byte i in bits 8i+7..8i |
| tx_end | input | 1 | End of transaction: flush all records |
| tx_abort | input | 1 | Abort: discard all records |
| log_valid | output | 1 | A log record is offered |
| log_ready | input | 1 | Persistent memory takes the record |
| log_line | output | LINE_AW | Line address of the record |
| log_mask | output | LINE_BYTES | Bytes written by the transaction |
| log_data | output | 8*LINE_BYTES | New line contents |
| log_tail | output | TAIL_W | Log index of the offered record |
| persisted | output | 1 | All records of the ended transaction are written |

## Verification
The bound checker watches the log port protocol on every cycle. It checks that a stalled record holds still, that the tail moves by exactly one per accepted record and otherwise stays put, that stores are refused while a record is stuck or a control pulse is present, and that the persisted flag never overlaps a pending record and falls after a new store. Whether bytes merge correctly, which line an eviction picks, the flush order and the dropping of records on abort all depend on the history of stores. Only the bench scenarios can show these, by comparing each emitted record against values worked out from the store sequence.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  // Transaction phase of the buffer
  typedef enum logic [1:0] {
    RCB_OPEN  = 2'd0,   // accepting stores of a running transaction
    RCB_DRAIN = 2'd1,   // flushing remaining records
    RCB_DONE  = 2'd2    // all records written, waiting for next store
  } rcb_state_e;

endpackage

// File: rtl/rcb_merge.sv
module rcb_merge #(
  parameter int BYTES = 8
) (
  input  logic [BYTES*8-1:0] old_data,
  input  logic [BYTES*8-1:0] new_data,
  input  logic [BYTES-1:0]   mask,
  output logic [BYTES*8-1:0] merged
);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = mask[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
  end

endmodule

// File: rtl/rcb_match.sv
module rcb_match #(
  parameter int N     = 4,
  parameter int AW    = 16,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0][AW-1:0] lines,
  input  logic [N-1:0]         vld,
  input  logic [AW-1:0]        query,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = vld[i] && (lines[i] == query);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/rcb_queue.sv
module rcb_queue #(
  parameter int N     = 4,
  parameter int AW    = 16,
  parameter int BYTES = 8,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          pop,
  input  logic                          push,
  input  logic [AW-1:0]                 push_line,
  input  logic [BYTES-1:0]              push_mask,
  input  logic [BYTES*8-1:0]            push_data,
  input  logic                          upd,
  input  logic [IDX_W-1:0]              upd_idx,
  input  logic [BYTES-1:0]              upd_mask,
  input  logic [BYTES*8-1:0]            upd_data,
  output logic [N-1:0][AW-1:0]          lines_o,
  output logic [N-1:0][BYTES-1:0]       masks_o,
  output logic [N-1:0][BYTES*8-1:0]     datas_o,
  output logic [N-1:0]                  vld_o,
  output logic [CNT_W-1:0]              cnt_o
);

  localparam int DW = BYTES * 8;

  // Slot 0 always holds the earliest allocation; slots are kept compacted.
  logic [N-1:0][AW-1:0]    line_q, line_n;
  logic [N-1:0][BYTES-1:0] mask_q, mask_n;
  logic [N-1:0][DW-1:0]    data_q, data_n;
  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [CNT_W-1:0]        wpos;
  logic                    slot_en;

  assign slot_en = pop || push || upd;
  assign wpos    = cnt_q - CNT_W'(pop);

  always_comb begin
    line_n = line_q;
    mask_n = mask_q;
    data_n = data_q;
    if (pop) begin
      for (int i = 0; i < N - 1; i++) begin
        line_n[i] = line_q[i+1];
        mask_n[i] = mask_q[i+1];
        data_n[i] = data_q[i+1];
      end
      line_n[N-1] = '0;
      mask_n[N-1] = '0;
      data_n[N-1] = '0;
    end
    for (int i = 0; i < N; i++) begin
      if (push && (CNT_W'(i) == wpos)) begin
        line_n[i] = push_line;
        mask_n[i] = push_mask;
        data_n[i] = push_data;
      end
      if (upd && (IDX_W'(i) == upd_idx)) begin
        mask_n[i] = upd_mask;
        data_n[i] = upd_data;
      end
    end
  end

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt_q - CNT_W'(pop) + CNT_W'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // Payload storage: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (slot_en) begin
      line_q <= line_n;
      mask_q <= mask_n;
      data_q <= data_n;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_vld
    assign vld_o[i] = (CNT_W'(i) < cnt_q);
  end

  assign lines_o = line_q;
  assign masks_o = mask_q;
  assign datas_o = data_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/redo_coalesce_buf.sv
module redo_coalesce_buf
  import rcb_pkg::*;
#(
  parameter int N_SLOTS    = 4,
  parameter int LINE_AW    = 16,
  parameter int LINE_BYTES = 8,
  parameter int TAIL_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [LINE_AW-1:0]      st_line,
  input  logic [LINE_BYTES-1:0]   st_mask,
  input  logic [LINE_BYTES*8-1:0] st_data,
  input  logic                    tx_end,
  input  logic                    tx_abort,
  output logic                    log_valid,
  input  logic                    log_ready,
  output logic [LINE_AW-1:0]      log_line,
  output logic [LINE_BYTES-1:0]   log_mask,
  output logic [LINE_BYTES*8-1:0] log_data,
  output logic [TAIL_W-1:0]       log_tail,
  output logic                    persisted
);

  localparam int DATA_W = LINE_BYTES * 8;
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int CNT_W  = $clog2(N_SLOTS + 1);

  rcb_state_e st_q, st_n;

  logic [N_SLOTS-1:0][LINE_AW-1:0]    q_lines;
  logic [N_SLOTS-1:0][LINE_BYTES-1:0] q_masks;
  logic [N_SLOTS-1:0][DATA_W-1:0]     q_datas;
  logic [N_SLOTS-1:0]                 q_vld;
  logic [CNT_W-1:0]                   q_cnt;

  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               out_free, acc_ok, st_fire;
  logic               full, evict, drain_pop, pop, push, upd, clr;
  logic [DATA_W-1:0]  upd_data, new_data;
  logic [LINE_BYTES-1:0] upd_mask;

  // Output register
  logic                  lv_q, lv_n;
  logic [LINE_AW-1:0]    ol_q;
  logic [LINE_BYTES-1:0] om_q;
  logic [DATA_W-1:0]     od_q;
  logic [TAIL_W-1:0]     tail_q, tail_n;

  // ---------------- control ----------------
  assign out_free  = !lv_q || log_ready;
  assign acc_ok    = (st_q != RCB_DRAIN) && out_free && !tx_end && !tx_abort;
  assign st_fire   = st_valid && acc_ok;
  assign full      = (q_cnt == CNT_W'(N_SLOTS));
  assign evict     = st_fire && !hit && full;
  assign push      = st_fire && !hit;
  assign upd       = st_fire && hit;
  assign drain_pop = (st_q == RCB_DRAIN) && out_free && (q_cnt != '0);
  assign pop       = evict || drain_pop;
  assign clr       = tx_abort && !tx_end && (st_q == RCB_OPEN);

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      RCB_OPEN: begin
        if (tx_end) st_n = RCB_DRAIN;
      end
      RCB_DRAIN: begin
        if ((q_cnt == '0) && out_free) st_n = RCB_DONE;
      end
      RCB_DONE: begin
        if (st_fire) st_n = RCB_OPEN;
      end
      default: st_n = RCB_OPEN;
    endcase
  end

  always_comb begin
    lv_n = lv_q;
    if (lv_q && log_ready) lv_n = 1'b0;
    if (pop)               lv_n = 1'b1;
  end

  assign tail_n = tail_q + TAIL_W'(lv_q && log_ready);

  // ---------------- datapath ----------------
  rcb_match #(
    .N     (N_SLOTS),
    .AW    (LINE_AW),
    .IDX_W (IDX_W)
  ) u_match (
    .lines (q_lines),
    .vld   (q_vld),
    .query (st_line),
    .hit   (hit),
    .idx   (hit_idx)
  );

  rcb_merge #(.BYTES(LINE_BYTES)) u_merge_hit (
    .old_data (q_datas[hit_idx]),
    .new_data (st_data),
    .mask     (st_mask),
    .merged   (upd_data)
  );

  rcb_merge #(.BYTES(LINE_BYTES)) u_merge_new (
    .old_data ('0),
    .new_data (st_data),
    .mask     (st_mask),
    .merged   (new_data)
  );

  assign upd_mask = q_masks[hit_idx] | st_mask;

  rcb_queue #(
    .N     (N_SLOTS),
    .AW    (LINE_AW),
    .BYTES (LINE_BYTES),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .pop       (pop),
    .push      (push),
    .push_line (st_line),
    .push_mask (st_mask),
    .push_data (new_data),
    .upd       (upd),
    .upd_idx   (hit_idx),
    .upd_mask  (upd_mask),
    .upd_data  (upd_data),
    .lines_o   (q_lines),
    .masks_o   (q_masks),
    .datas_o   (q_datas),
    .vld_o     (q_vld),
    .cnt_o     (q_cnt)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RCB_OPEN;
      lv_q   <= 1'b0;
      tail_q <= '0;
    end else begin
      st_q   <= st_n;
      lv_q   <= lv_n;
      tail_q <= tail_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      ol_q <= q_lines[0];
      om_q <= q_masks[0];
      od_q <= q_datas[0];
    end
  end

  assign st_ready  = acc_ok;
  assign log_valid = lv_q;
  assign log_line  = ol_q;
  assign log_mask  = om_q;
  assign log_data  = od_q;
  assign log_tail  = tail_q;
  assign persisted = (st_q == RCB_DONE);

endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
  parameter int AW = 16,
  parameter int DW = 64,
  parameter int MW = 8,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          tx_end,
  input logic          tx_abort,
  input logic          log_valid,
  input logic          log_ready,
  input logic [AW-1:0] log_line,
  input logic [MW-1:0] log_mask,
  input logic [DW-1:0] log_data,
  input logic [TW-1:0] log_tail,
  input logic          persisted
);

  a_r5_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |=> (log_valid && $stable(log_line) && $stable(log_mask)
                                   && $stable(log_data) && $stable(log_tail)));

  a_r8_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && log_ready) |=> (log_tail == $past(log_tail) + TW'(1)));

  a_r8_tail_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(log_valid && log_ready) |=> $stable(log_tail));

  a_r6_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |-> !st_ready);

  a_r6_stall_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end || tx_abort) |-> !st_ready);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    persisted |-> !log_valid);

  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (persisted && !(st_valid && st_ready)) |=> persisted);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (persisted && st_valid && st_ready) |=> !persisted);

endmodule

bind redo_coalesce_buf rcb_checker #(
  .AW (LINE_AW),
  .DW (LINE_BYTES*8),
  .MW (LINE_BYTES),
  .TW (TAIL_W)
) u_rcb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .tx_end    (tx_end),
  .tx_abort  (tx_abort),
  .log_valid (log_valid),
  .log_ready (log_ready),
  .log_line  (log_line),
  .log_mask  (log_mask),
  .log_data  (log_data),
  .log_tail  (log_tail),
  .persisted (persisted)
);

// File: tb/redo_coalesce_buf_bench.sv
module redo_coalesce_buf_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready, tx_end, tx_abort;
  logic [15:0] st_line;
  logic [7:0]  st_mask;
  logic [63:0] st_data;
  logic        log_valid, log_ready, persisted;
  logic [15:0] log_line, log_tail;
  logic [7:0]  log_mask;
  logic [63:0] log_data;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  redo_coalesce_buf u_redo_coalesce_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
    .st_mask(st_mask), .st_data(st_data),
    .tx_end(tx_end), .tx_abort(tx_abort),
    .log_valid(log_valid), .log_ready(log_ready), .log_line(log_line),
    .log_mask(log_mask), .log_data(log_data), .log_tail(log_tail),
    .persisted(persisted)
  );

  typedef struct packed {
    logic [15:0] line;
    logic [7:0]  mask;
    logic [7:0]  byt;
    logic        ev;
    logic [15:0] eline;
    logic [7:0]  emask;
    logic [63:0] edata;
    logic [15:0] etail;
  } vec_t;

  // One store per row; ev marks rows whose store evicts the oldest record
  localparam vec_t VEC [9] = '{
    '{16'h0010, 8'h01, 8'h11, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0010, 8'h02, 8'h22, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0020, 8'hF0, 8'h33, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0030, 8'h01, 8'h44, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0040, 8'h80, 8'h55, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0010, 8'h04, 8'h66, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0050, 8'hFF, 8'h77, 1'b1, 16'h0010, 8'h07, 64'h0000_0000_0066_2211, 16'd0},
    '{16'h0020, 8'h0F, 8'h88, 1'b0, 16'h0,    8'h00, 64'h0, 16'd0},
    '{16'h0060, 8'h03, 8'h99, 1'b1, 16'h0020, 8'hFF, 64'h3333_3333_8888_8888, 16'd1}
  };

  logic [15:0] drn_line [4] = '{16'h0030, 16'h0040, 16'h0050, 16'h0060};
  logic [7:0]  drn_mask [4] = '{8'h01, 8'h80, 8'hFF, 8'h03};
  logic [63:0] drn_data [4] = '{64'h44, 64'h5500_0000_0000_0000,
                                64'h7777_7777_7777_7777, 64'h9999};

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [15:0] l, input logic [7:0] m, input logic [7:0] b);
    @(negedge clk);
    st_line  = l;
    st_mask  = m;
    st_data  = {8{b}};
    st_valid = 1'b1;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0; st_valid = 1'b0; tx_end = 1'b0; tx_abort = 1'b0;
    log_ready = 1'b1; st_line = '0; st_mask = '0; st_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(log_valid == 1'b0, "R1 log_valid", 64'(log_valid), 0);
    chk(persisted == 1'b0, "R1 persisted", 64'(persisted), 0);
    chk(log_tail == 16'd0, "R1 log_tail", 64'(log_tail), 0);
    chk(st_ready == 1'b1, "R1 st_ready", 64'(st_ready), 1);

    // Table walk: R2 merges, R3 allocation, R4 FIFO eviction, R8 tail
    for (int i = 0; i < 9; i++) begin
      do_store(VEC[i].line, VEC[i].mask, VEC[i].byt);
      chk(log_valid == VEC[i].ev, "R4 eviction presence", 64'(log_valid), 64'(VEC[i].ev));
      if (VEC[i].ev) begin
        chk(log_line == VEC[i].eline, "R4 evicted line", 64'(log_line), 64'(VEC[i].eline));
        chk(log_mask == VEC[i].emask, "R3 record mask", 64'(log_mask), 64'(VEC[i].emask));
        chk(log_data == VEC[i].edata, "R2 merged data", log_data, VEC[i].edata);
        chk(log_tail == VEC[i].etail, "R8 record tail", 64'(log_tail), 64'(VEC[i].etail));
      end
    end

    // R7 flush in allocation order under a stuttering log_ready
    @(negedge clk);
    tx_end = 1'b1;
    #1 chk(st_ready == 1'b0, "R6 st_ready during tx_end", 64'(st_ready), 0);
    @(negedge clk);
    tx_end = 1'b0;
    k = 0;
    for (int c = 0; c < 40; c++) begin
      if (persisted) break;
      chk(st_ready == 1'b0, "R6 st_ready while flushing", 64'(st_ready), 0);
      log_ready = (c % 3) != 0;
      if (log_valid && log_ready) begin
        if (k < 4) begin
          chk(log_line == drn_line[k], "R7 flush order", 64'(log_line), 64'(drn_line[k]));
          chk(log_mask == drn_mask[k], "R7 flush mask", 64'(log_mask), 64'(drn_mask[k]));
          chk(log_data == drn_data[k], "R7 flush data", log_data, drn_data[k]);
          chk(log_tail == 16'(k + 2), "R8 flush tail", 64'(log_tail), 64'(k + 2));
        end
        k++;
      end
      @(negedge clk);
    end
    log_ready = 1'b1;
    chk(k == 4, "R7 flushed record count", 64'(k), 4);
    chk(persisted == 1'b1, "R9 persisted after flush", 64'(persisted), 1);
    chk(log_tail == 16'd6, "R8 tail after flush", 64'(log_tail), 6);

    // R9 flag holds while idle, drops after the next accepted store
    @(negedge clk);
    chk(persisted == 1'b1, "R9 persisted holds", 64'(persisted), 1);
    do_store(16'h00A0, 8'hFF, 8'hA5);
    chk(persisted == 1'b0, "R9 persisted cleared by store", 64'(persisted), 0);
    do_store(16'h00B0, 8'h0F, 8'hB5);

    // R10 abort discards, then an empty flush writes nothing
    @(negedge clk);
    tx_abort = 1'b1;
    #1 chk(st_ready == 1'b0, "R6 st_ready during tx_abort", 64'(st_ready), 0);
    @(negedge clk);
    tx_abort = 1'b0;
    tx_end = 1'b1;
    @(negedge clk);
    tx_end = 1'b0;
    k = 0;
    for (int c = 0; c < 8; c++) begin
      if (log_valid) k++;
      @(negedge clk);
    end
    chk(k == 0, "R10 no record after abort", 64'(k), 0);
    chk(persisted == 1'b1, "R7 empty flush completes", 64'(persisted), 1);
    chk(log_tail == 16'd6, "R8 abort leaves tail", 64'(log_tail), 6);

    // R4/R5/R6 eviction under back-pressure
    do_store(16'h00C0, 8'hFF, 8'h01);
    do_store(16'h00C1, 8'hFF, 8'h02);
    do_store(16'h00C2, 8'hFF, 8'h03);
    do_store(16'h00C3, 8'hFF, 8'h04);
    log_ready = 1'b0;
    do_store(16'h00C4, 8'hFF, 8'h05);
    chk(log_valid == 1'b1, "R4 eviction when full", 64'(log_valid), 1);
    chk(log_line == 16'h00C0, "R4 oldest evicted", 64'(log_line), 64'h00C0);
    @(negedge clk);
    st_line = 16'h00C1; st_mask = 8'h01; st_data = '0; st_valid = 1'b1;
    #1 chk(st_ready == 1'b0, "R6 st_ready with stuck record", 64'(st_ready), 0);
    @(negedge clk);
    st_valid = 1'b0;
    chk(log_line == 16'h00C0, "R5 record held", 64'(log_line), 64'h00C0);
    chk(log_data == {8{8'h01}}, "R5 data held", log_data, {8{8'h01}});
    chk(log_tail == 16'd6, "R5 tail held", 64'(log_tail), 6);
    log_ready = 1'b1;
    @(negedge clk);
    chk(log_valid == 1'b0, "R5 record leaves on ready", 64'(log_valid), 0);
    chk(log_tail == 16'd7, "R8 tail after eviction", 64'(log_tail), 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule